// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

This block holds two 8-bit up-counting interval timers, called lower and upper. Each has its own compare register, a match detector and a wrap detector. Both timers run on one system clock. Counting is gated by single-cycle enable pulses that a free-running 11-bit divider produces. The lower timer can also count rising edges of an external pin, which is synchronised inside the block. The upper timer can count divider pulses or the lower timer's match pulses. A mode field can also join the two timers into a single 16-bit counter, with the lower timer's wrap carrying into the upper timer.

Two further modes change only how the lower timer restarts and when its compare register is refreshed. In the free-run mode the lower timer counts through its full range and never clears on a match. In the pulse-period mode it clears on a match, as in plain 8-bit mode. With double buffering enabled, software writes to the lower compare register go to a shadow copy. The shadow is loaded into the live register at the lower wrap in free-run mode, and at the lower match in every other mode. Software programs the block through a write-only bus with an address, a data byte and a write strobe.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counts are 0, every pulse output is low, the mode is 00, both timers are stopped, double buffering is off and all clock selects are 00.
- R2: Register 3 holds bit 0 = run lower and bit 1 = run upper. A stopped timer holds a count of 0, and clearing a run bit returns the count to 0 on the next edge.
- R3: Register 2 holds mode in bits [1:0], lower select in [3:2] and upper select in [5:4]. Lower select 00, 01 and 10 count one step on each divider pulse of period 8, 32 and 128 cycles. The pulse of period 2^k fires when the low k bits of the divider, which starts at 0 after reset, are all ones.
- R4: Lower select 11 counts each rising edge of the external pin once. The edge is seen after a two-flop synchroniser plus one edge-detect flop.
- R5: When a step brings a count to its nonzero compare value (register 0 for lower, register 1 for upper), the match output pulses high for exactly the following cycle. In modes 00 and 11 the count is cleared on the edge after that. A clear takes priority over a step in the same cycle.
- R6: A compare value of 0 makes the match fire on the step that wraps the count from 255 to 0.
- R7: The overflow output pulses for one cycle after any step that wraps a count from 255 to 0.
- R8: Outside mode 01, upper select 00, 01, 10 and 11 steps the upper timer on the lower match pulse and on divider pulses of period 8, 128 and 2048.
- R9: In mode 01 the lower wrap steps the upper timer. The upper match output signals that the 16-bit count {upper, lower} has stepped to {reg1, reg0}, or has wrapped from FFFFh when both compare registers are 0. That match clears both halves. The lower match output keeps its 8-bit meaning.
- R10: In mode 10 the lower timer never clears on its match and counts through 255 to 0.
- R11: Register 4 bit 0 enables double buffering. When it is 0, writes to register 0 take effect at once. When it is 1, those writes land in a shadow, which is copied to the compare register on the lower wrap in mode 10 and on the lower match in other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe, one write per cycle it is high |
| ext_clk_i | input | 1 | External count pin for the lower timer |
| lo_match_o | output | 1 | Lower match pulse |
| hi_match_o | output | 1 | Upper match pulse (16-bit match in mode 01) |
| lo_ovf_o | output | 1 | Lower wrap pulse |
| hi_ovf_o | output | 1 | Upper wrap pulse |
| lo_count_o | output | 8 | Lower count |
| hi_count_o | output | 8 | Upper count |

## Verification
The bench targets a compare value of zero. A design that compared against zero literally would fire once at the start and then never again, instead of at each wrap. It also checks that the 16-bit match waits for both halves, since matching on the lower half alone would clear the pair 256 times too early. Other cases covered are the external pin and the double-buffer reload points. A missing synchroniser stage shifts every external step by one cycle. A reload taken at the wrong event leaves the old compare value in force for a whole extra period. The upper timer's 2048-cycle and match-driven clocks are checked, because a swapped select code changes its period by a large factor.

// File: rtl/dit_pkg.sv
package dit_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT = 2'b00,
    MODE_JOIN  = 2'b01,
    MODE_FREE  = 2'b10,
    MODE_PULSE = 2'b11
  } dit_mode_e;

  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_RUN    = 3'd3;
  localparam logic [ADDR_W-1:0] A_DBUF   = 3'd4;

  localparam int unsigned N_TAPS = 4;
endpackage

// File: rtl/dit_prescaler.sv
module dit_prescaler #(
  parameter int unsigned DIV_W = 11
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  output logic [dit_pkg::N_TAPS-1:0]  tick_o
);
  localparam int unsigned TAP_W [dit_pkg::N_TAPS] = '{3, 5, 7, DIV_W};

  logic [DIV_W-1:0] div_q, div_d;

  always_comb div_d = div_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  for (genvar g = 0; g < dit_pkg::N_TAPS; g++) begin : g_tap
    localparam logic [DIV_W-1:0] MASK = DIV_W'((64'd1 << TAP_W[g]) - 64'd1);
    assign tick_o[g] = ((div_q & MASK) == MASK);
  end

  // R3: the fastest pulse never repeats on consecutive cycles
  a_r3_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o[0] |=> !tick_o[0]);
endmodule

// File: rtl/dit_ext_sync.sv
module dit_ext_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [2:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[1:0], pin_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rise_o = sh_q[1] & ~sh_q[2];

  // R4: one step per edge
  a_r4_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o,
  output logic         adv_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;

  assign adv_o  = run_i & ~clr_i & tick_i;
  assign nxt_o  = cnt_q + 1'b1;
  assign wrap_o = adv_o & (cnt_q == '1);
  assign cnt_o  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)     cnt_d = '0;
    else if (clr_i) cnt_d = '0;
    else if (tick_i) cnt_d = nxt_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R2: a stopped timer sits at zero
  a_r2_held_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned DIV_W      = 11,
  parameter bit          EXT_CLK_EN = 1'b1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [dit_pkg::ADDR_W-1:0]  bus_addr_i,
  input  logic [CNT_W-1:0]            bus_wdata_i,
  input  logic                        bus_we_i,
  input  logic                        ext_clk_i,
  output logic                        lo_match_o,
  output logic                        hi_match_o,
  output logic                        lo_ovf_o,
  output logic                        hi_ovf_o,
  output logic [CNT_W-1:0]            lo_count_o,
  output logic [CNT_W-1:0]            hi_count_o
);
  import dit_pkg::*;

  localparam int unsigned W2 = 2 * CNT_W;

  dit_mode_e        mode_q, mode_d;
  logic [1:0]       lsel_q, lsel_d, hsel_q, hsel_d, run_q, run_d;
  logic             dbuf_q, dbuf_d;
  logic [CNT_W-1:0] cmp_lo_q, cmp_lo_d, shadow_q, shadow_d, cmp_hi_q, cmp_hi_d;
  logic             lm_q, hm_q, lov_q, hov_q;
  logic             lm_d, hm_d;

  logic [N_TAPS-1:0] tick;
  logic              ext_rise;
  logic              joined, free_run;
  logic              lo_tick, lo_clr, lo_adv, lo_wrap;
  logic              hi_tick, hi_clr, hi_adv, hi_wrap;
  logic [CNT_W-1:0]  lo_cnt, lo_nxt, hi_cnt, hi_nxt;
  logic [W2-1:0]     cnt16, cmp16;
  logic              m16, hm8, reload;

  dit_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  if (EXT_CLK_EN) begin : g_ext
    dit_ext_sync u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(ext_clk_i), .rise_o(ext_rise)
    );
  end else begin : g_no_ext
    assign ext_rise = 1'b0;
  end

  assign joined   = (mode_q == MODE_JOIN);
  assign free_run = (mode_q == MODE_FREE);

  always_comb begin
    unique case (lsel_q)
      2'd0:    lo_tick = tick[0];
      2'd1:    lo_tick = tick[1];
      2'd2:    lo_tick = tick[2];
      default: lo_tick = ext_rise;
    endcase
    lo_clr = joined ? hm_q : (free_run ? 1'b0 : lm_q);
  end

  dit_counter #(.W(CNT_W)) u_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q[0]), .clr_i(lo_clr),
    .tick_i(lo_tick), .cnt_o(lo_cnt), .nxt_o(lo_nxt), .adv_o(lo_adv),
    .wrap_o(lo_wrap)
  );

  always_comb begin
    if (joined) hi_tick = lo_wrap;
    else begin
      unique case (hsel_q)
        2'd0:    hi_tick = lm_q;
        2'd1:    hi_tick = tick[0];
        2'd2:    hi_tick = tick[2];
        default: hi_tick = tick[3];
      endcase
    end
    hi_clr = hm_q;
  end

  dit_counter #(.W(CNT_W)) u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q[1]), .clr_i(hi_clr),
    .tick_i(hi_tick), .cnt_o(hi_cnt), .nxt_o(hi_nxt), .adv_o(hi_adv),
    .wrap_o(hi_wrap)
  );

  // match detection and shadow reload
  always_comb begin
    cnt16 = {hi_cnt, lo_cnt};
    cmp16 = {cmp_hi_q, cmp_lo_q};
    lm_d  = lo_adv & ((cmp_lo_q != '0) ? (lo_nxt == cmp_lo_q) : (lo_cnt == '1));
    hm8   = hi_adv & ((cmp_hi_q != '0) ? (hi_nxt == cmp_hi_q) : (hi_cnt == '1));
    m16   = lo_adv & run_q[1] &
            ((cmp16 != '0) ? (W2'(cnt16 + 1'b1) == cmp16) : (cnt16 == '1));
    hm_d  = joined ? m16 : hm8;
    reload = dbuf_q & (free_run ? lo_wrap : lm_d);
  end

  // register file next state
  always_comb begin
    mode_d   = mode_q;
    lsel_d   = lsel_q;
    hsel_d   = hsel_q;
    run_d    = run_q;
    dbuf_d   = dbuf_q;
    cmp_hi_d = cmp_hi_q;
    shadow_d = shadow_q;
    cmp_lo_d = reload ? shadow_q : cmp_lo_q;
    if (bus_we_i) begin
      unique case (bus_addr_i)
        A_CMP_LO: if (dbuf_q) shadow_d = bus_wdata_i;
                  else        cmp_lo_d = bus_wdata_i;
        A_CMP_HI: cmp_hi_d = bus_wdata_i;
        A_CTRL: begin
          mode_d = dit_mode_e'(bus_wdata_i[1:0]);
          lsel_d = bus_wdata_i[3:2];
          hsel_d = bus_wdata_i[5:4];
        end
        A_RUN:  run_d  = bus_wdata_i[1:0];
        A_DBUF: dbuf_d = bus_wdata_i[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_SPLIT;
      lsel_q   <= '0;
      hsel_q   <= '0;
      run_q    <= '0;
      dbuf_q   <= 1'b0;
      cmp_lo_q <= '0;
      shadow_q <= '0;
      cmp_hi_q <= '0;
      lm_q     <= 1'b0;
      hm_q     <= 1'b0;
      lov_q    <= 1'b0;
      hov_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      lsel_q   <= lsel_d;
      hsel_q   <= hsel_d;
      run_q    <= run_d;
      dbuf_q   <= dbuf_d;
      cmp_lo_q <= cmp_lo_d;
      shadow_q <= shadow_d;
      cmp_hi_q <= cmp_hi_d;
      lm_q     <= lm_d;
      hm_q     <= hm_d;
      lov_q    <= lo_wrap;
      hov_q    <= hi_wrap;
    end
  end

  assign lo_match_o = lm_q;
  assign hi_match_o = hm_q;
  assign lo_ovf_o   = lov_q;
  assign hi_ovf_o   = hov_q;
  assign lo_count_o = lo_cnt;
  assign hi_count_o = hi_cnt;

  // R5: match is a single-cycle pulse
  a_r5_match_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lm_q |=> !lm_q);
  // R5: split and pulse-period modes restart the lower count after a match
  a_r5_match_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lm_q && !free_run && !joined) |=> lo_cnt == '0);
  // R7: the wrap pulse coincides with a zero count
  a_r7_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lov_q |-> lo_cnt == '0);
  // R9: a 16-bit match clears both halves
  a_r9_joint_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hm_q && joined) |=> (lo_cnt == '0 && hi_cnt == '0));
  // R10: free-run mode never clears on a lower match
  a_r10_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lm_q && free_run && run_q[0] && !lo_tick && !bus_we_i) |=> $stable(lo_cnt));
endmodule

// File: tb/dual_interval_timer_tb.sv
module dual_interval_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic       ext = 1'b0;
  logic       lo_m, hi_m, lo_v, hi_v;
  logic [7:0] lo_c, hi_c;

  int total = 0, bad = 0, cyc = 0;
  bit cmp_on = 1'b0, done = 1'b0;
  string cur_req = "R1";
  int n_lm = 0, n_hm = 0, n_lv = 0, n_hv = 0;

  // reference model state
  int m_div, m_mode, m_lsel, m_hsel, m_run, m_dbuf;
  int m_clo, m_sh, m_chi, m_lo, m_hi;
  int m_lm, m_hm, m_lv, m_hv, m_s1, m_s2, m_s3;

  always #5 clk = ~clk;

  dual_interval_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_we_i(we), .ext_clk_i(ext), .lo_match_o(lo_m), .hi_match_o(hi_m),
    .lo_ovf_o(lo_v), .hi_ovf_o(hi_v), .lo_count_o(lo_c), .hi_count_o(hi_c)
  );

  always @(posedge clk) begin
    int t8, t32, t128, t2048, lt, ht, lclr, ladv, lwrap, lmc;
    int hadv, hwrap, hmc, v16, c16, j, pwm, rel, nlo, nhi, nclo, nsh;
    if (!rst_n) begin
      m_div = 0; m_mode = 0; m_lsel = 0; m_hsel = 0; m_run = 0; m_dbuf = 0;
      m_clo = 0; m_sh = 0; m_chi = 0; m_lo = 0; m_hi = 0;
      m_lm = 0; m_hm = 0; m_lv = 0; m_hv = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      t8 = (m_div % 8 == 7); t32 = (m_div % 32 == 31);
      t128 = (m_div % 128 == 127); t2048 = (m_div == 2047);
      j = (m_mode == 1); pwm = (m_mode == 2);
      case (m_lsel)
        0: lt = t8; 1: lt = t32; 2: lt = t128; default: lt = (m_s2 && !m_s3);
      endcase
      lclr  = j ? m_hm : (pwm ? 0 : m_lm);
      ladv  = (m_run % 2) && !lclr && lt;
      lwrap = ladv && m_lo == 255;
      lmc   = ladv && ((m_clo != 0) ? ((m_lo + 1) % 256 == m_clo) : (m_lo == 255));
      if (j) ht = lwrap;
      else case (m_hsel)
        0: ht = m_lm; 1: ht = t8; 2: ht = t128; default: ht = t2048;
      endcase
      hadv  = (m_run / 2) && !m_hm && ht;
      hwrap = hadv && m_hi == 255;
      v16 = m_hi * 256 + m_lo; c16 = m_chi * 256 + m_clo;
      if (j) hmc = ladv && (m_run / 2) && ((c16 != 0) ? ((v16 + 1) % 65536 == c16) : (v16 == 65535));
      else   hmc = hadv && ((m_chi != 0) ? ((m_hi + 1) % 256 == m_chi) : (m_hi == 255));
      rel = m_dbuf && (pwm ? lwrap : lmc);
      nlo = !(m_run % 2) ? 0 : lclr ? 0 : lt ? (m_lo + 1) % 256 : m_lo;
      nhi = !(m_run / 2) ? 0 : m_hm ? 0 : ht ? (m_hi + 1) % 256 : m_hi;
      nclo = rel ? m_sh : m_clo; nsh = m_sh;
      if (we) begin
        case (addr)
          0: if (m_dbuf) nsh = wdata; else nclo = wdata;
          1: m_chi = wdata;
          2: begin m_mode = wdata[1:0]; m_lsel = wdata[3:2]; m_hsel = wdata[5:4]; end
          3: m_run = wdata[1:0];
          4: m_dbuf = wdata[0];
          default: ;
        endcase
      end
      m_clo = nclo; m_sh = nsh; m_lo = nlo; m_hi = nhi;
      m_lm = lmc; m_hm = hmc; m_lv = lwrap; m_hv = hwrap;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext;
      m_div = (m_div + 1) % 2048;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(cur_req, "lo_count", lo_c, m_lo);
      chk(cur_req, "hi_count", hi_c, m_hi);
      chk(cur_req, "lo_match", lo_m, m_lm);
      chk(cur_req, "hi_match", hi_m, m_hm);
      chk(cur_req, "lo_ovf", lo_v, m_lv);
      chk(cur_req, "hi_ovf", hi_v, m_hv);
      n_lm += lo_m; n_hm += hi_m; n_lv += lo_v; n_hv += hi_v;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr_counts();
    n_lm = 0; n_hm = 0; n_lv = 0; n_hv = 0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;
    // R1: reset state
    chk("R1", "lo_count", lo_c, 0);
    chk("R1", "hi_count", hi_c, 0);
    chk("R1", "pulses", {lo_m, hi_m, lo_v, hi_v}, 0);
    idle(20);
    chk("R1", "stopped lo_count", lo_c, 0);

    // R5: split mode, lower /8, compare 5
    cur_req = "R5"; clr_counts();
    wr(0, 8'd5); wr(2, 8'h00); wr(3, 8'h01);
    idle(300);
    chk("R5", "match seen", (n_lm > 0), 1);

    // R2: stop clears
    cur_req = "R2";
    wr(3, 8'h00); idle(2);
    chk("R2", "stopped lo_count", lo_c, 0);

    // R3: /32 and /128 selects
    cur_req = "R3";
    wr(0, 8'd3); wr(2, 8'b0000_0100); wr(3, 8'h01); idle(400);
    wr(3, 8'h00); wr(2, 8'b0000_1000); wr(0, 8'd2); wr(3, 8'h01); idle(800);

    // R6 and R7: compare zero, wrap
    cur_req = "R6"; clr_counts();
    wr(3, 8'h00); wr(0, 8'd0); wr(2, 8'h00); wr(3, 8'h01); idle(2200);
    chk("R6", "match on wrap", (n_lm > 0), 1);
    chk("R7", "overflow seen", (n_lv > 0), 1);

    // R4: external pin
    cur_req = "R4"; clr_counts();
    wr(3, 8'h00); wr(0, 8'd4); wr(2, 8'b0000_1100); wr(3, 8'h01);
    for (int i = 0; i < 12; i++) begin
      ext = 1'b1; idle(3); ext = 1'b0; idle(3);
    end
    idle(5);
    chk("R4", "external matches", n_lm, 3);

    // R8: upper selects
    cur_req = "R8"; clr_counts();
    wr(3, 8'h00); wr(0, 8'd2); wr(1, 8'd3); wr(2, 8'b0000_0000); wr(3, 8'h03); idle(300);
    chk("R8", "upper match from lower", (n_hm > 0), 1);
    wr(3, 8'h00); wr(1, 8'd7); wr(2, 8'b0001_0000); wr(3, 8'h03); idle(300);
    wr(3, 8'h00); wr(1, 8'd2); wr(2, 8'b0011_0000); wr(3, 8'h03); idle(4300);
    wr(3, 8'h00); wr(1, 8'd2); wr(2, 8'b0010_0000); wr(3, 8'h03); idle(600);

    // R9: joined 16-bit mode
    cur_req = "R9"; clr_counts();
    wr(3, 8'h00); wr(0, 8'd3); wr(1, 8'd1); wr(2, 8'b0000_0001); wr(3, 8'h03); idle(4300);
    chk("R9", "16-bit match count", n_hm, 2);

    // R10 and R11: free-run with double buffer, reload at wrap
    cur_req = "R10"; clr_counts();
    wr(3, 8'h00); wr(4, 8'h00); wr(0, 8'd10); wr(4, 8'h01); wr(0, 8'd40);
    wr(2, 8'b0000_0010); wr(3, 8'h01); idle(4400);
    chk("R10", "wraps in free run", (n_lv > 0), 1);
    cur_req = "R11";
    // R11: pulse-period mode reloads at match
    wr(3, 8'h00); wr(0, 8'd6); wr(2, 8'b0000_0011); wr(3, 8'h01); idle(900);
    wr(3, 8'h00); wr(4, 8'h00); wr(0, 8'd9); wr(3, 8'h01); idle(200);
    finish_run();
  end
endmodule